// File: doc/BRIEF.md
# Flash Erase Status Register Logic

This block models the bus-read side of a NOR flash program/erase controller. It holds a small behavioural array of bytes split into equal blocks. It accepts command strobes for program, block erase, chip erase, erase suspend, erase resume and read/reset. It also takes controller events that mark the start of erasing, the end of an operation and which blocks failed to erase. It keeps a per-block bitmap of blocks queued for erase, honours a per-block protection mask, and remembers which blocks failed.

On every bus read the block returns one of two things. In plain read mode it returns array data. Otherwise it returns a status byte carrying an error flag (bit 5), an erase-timer flag (bit 3) and an alternate toggle flag (bit 2). A single shared toggle register inverts only on reads whose block is being erased, or, after a failed erase, on reads of a block that failed. A host can therefore poll the same status word to locate the bad blocks. While erase is suspended, reads outside the erase set see array data.

Top module: `flash_erase_status`

## Requirements
- R1: After reset the mode is plain read, every array byte reads 0xFF, the toggle flag is 0 and a read returns the array byte at the read address.
- R2: A program command (cmd code 1) in read mode stores old AND new data at the address. Until the done event, reads return a status byte with bits 5, 3 and 2 equal to 0, 0 and the current toggle. After the done event the block is back in read mode.
- R3: A program that asks to turn a 0 bit into 1 sets the error flag (bit 5) at once. The bit stays 0 in the array, and a read of that address after read/reset still shows 0.
- R4: While the error flag is set, every command except read/reset (cmd code 6) is ignored. Read/reset returns the block to read mode with the error cleared.
- R5: A block erase command (cmd code 2) enters erase setup. In setup the timer flag (bit 3) reads 0 and further block erase commands add their blocks to the erase set. After the start event, bit 3 reads 1.
- R6: During erase, bit 2 inverts after each read whose block (read address divided by words per block) is in the erase set. Reads of other blocks return status with bit 2 unchanged.
- R7: A block whose protection bit is 1 when the erase command arrives is never added to the erase set. Its data survives the erase, and reads of it do not move bit 2.
- R8: Suspend (cmd code 4) during erase makes reads of erasing blocks return toggling status, while reads of other blocks return array data. Resume (cmd code 5) continues the erase.
- R9: If the done event of an erase flags failed blocks inside the erase set, the error flag is set and bit 3 stays 1. Bit 2 then toggles only on reads of failed blocks, and failed blocks keep their old data.
- R10: An erase whose done event flags no failure sets every byte of the erased blocks to 0xFF, leaves other blocks untouched and returns to read mode.
- R11: Chip erase (cmd code 3) selects every unprotected block.
- R12: Status bits 7, 6, 4, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code: 0 nop, 1 program, 2 block erase, 3 chip erase, 4 suspend, 5 resume, 6 read/reset |
| cmd_addr_i | input | ADDR_W | Command address; upper bits pick the block |
| cmd_data_i | input | DATA_W | Program data |
| prot_i | input | NBLK | Per-block protection mask |
| ev_start_i | input | 1 | Controller begins erasing |
| ev_done_i | input | 1 | Controller finished the current operation |
| ev_fail_i | input | NBLK | Blocks that failed erase, sampled with ev_done_i |
| rd_en_i | input | 1 | Bus read strobe |
| rd_addr_i | input | ADDR_W | Bus read address |
| rd_data_o | output | DATA_W | Array data or status byte |

## Verification
On every cycle the assertions check four things: status bits outside 5, 3 and 2 stay 0, the timer flag is low during erase setup, the error mode is left only through read/reset, and a program write never sets a bit. They also check that the toggle flag holds still in plain read mode. Only the bench scenarios can show the rest. These are which blocks end up erased or kept, the exact toggle sequence across mixed addresses, and suspend returning array data outside the erase set. They also cover locating failed blocks after an erase error and the survival of protected and failed data.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_PROG   = 3'd1,
    CMD_BERASE = 3'd2,
    CMD_CERASE = 3'd3,
    CMD_SUSP   = 3'd4,
    CMD_RESUME = 3'd5,
    CMD_RESET  = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    M_READ  = 3'd0,
    M_PROG  = 3'd1,
    M_SETUP = 3'd2,
    M_BUSY  = 3'd3,
    M_SUSP  = 3'd4,
    M_ERROR = 3'd5
  } mode_e;

  localparam int ERR_BIT = 5;
  localparam int TMR_BIT = 3;
  localparam int TOG_BIT = 2;
endpackage

// File: rtl/fes_array.sv
module fes_array #(
  parameter int DATA_W = 8,
  parameter int NBLK   = 8,
  parameter int WPB    = 4,
  localparam int OFF_W  = $clog2(WPB),
  localparam int ADDR_W = $clog2(NBLK) + OFF_W,
  localparam int DEPTH  = NBLK * WPB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_we_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              erase_we_i,
  input  logic [NBLK-1:0]   erase_mask_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_q_o,
  output logic              prog_fault_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (erase_we_i) begin
      for (int i = 0; i < DEPTH; i++)
        if (erase_mask_i[i / WPB]) mem[i] <= '1;
    end else if (prog_we_i) begin
      mem[cmd_addr_i] <= mem[cmd_addr_i] & cmd_data_i;
    end
  end

  assign rd_q_o       = mem[rd_addr_i];
  assign prog_fault_o = |(cmd_data_i & ~mem[cmd_addr_i]);

  AST_PROG_ONLY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni) (prog_we_i && !erase_we_i) |=> ((mem[$past(cmd_addr_i)] & ~$past(mem[cmd_addr_i])) == '0)); // R3
endmodule

// File: rtl/fes_ctrl.sv
module fes_ctrl
  import fes_pkg::*;
#(
  parameter int NBLK = 8,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  cmd_e             cmd_i,
  input  logic [BLK_W-1:0] cmd_blk_i,
  input  logic [NBLK-1:0]  prot_i,
  input  logic             prog_fault_i,
  input  logic             ev_start_i,
  input  logic             ev_done_i,
  input  logic [NBLK-1:0]  ev_fail_i,
  output mode_e            mode_o,
  output logic [NBLK-1:0]  sel_o,
  output logic [NBLK-1:0]  failed_o,
  output logic             prog_we_o,
  output logic             erase_we_o,
  output logic [NBLK-1:0]  erase_mask_o
);
  mode_e           mode_q, mode_d;
  logic [NBLK-1:0] sel_q, sel_d, failed_q, failed_d;
  logic [NBLK-1:0] blk_bit, bad_blk;

  assign blk_bit = {{(NBLK-1){1'b0}}, 1'b1} << cmd_blk_i;
  assign bad_blk = sel_q & ev_fail_i;

  function automatic logic is_cmd(input logic v, input cmd_e c, input cmd_e want);
    return v && (c == want);
  endfunction

  always_comb begin
    mode_d       = mode_q;
    sel_d        = sel_q;
    failed_d     = failed_q;
    prog_we_o    = 1'b0;
    erase_we_o   = 1'b0;
    erase_mask_o = '0;
    unique case (mode_q)
      M_READ: begin
        if (is_cmd(cmd_valid_i, cmd_i, CMD_PROG)) begin
          prog_we_o = 1'b1;
          mode_d    = prog_fault_i ? M_ERROR : M_PROG;
        end else if (is_cmd(cmd_valid_i, cmd_i, CMD_BERASE)) begin
          sel_d  = prot_i[cmd_blk_i] ? '0 : blk_bit;
          mode_d = M_SETUP;
        end else if (is_cmd(cmd_valid_i, cmd_i, CMD_CERASE)) begin
          sel_d  = ~prot_i;
          mode_d = M_SETUP;
        end
      end
      M_PROG: if (ev_done_i) mode_d = M_READ;
      M_SETUP: begin
        if (ev_start_i) begin
          mode_d = M_BUSY;
        end else if (is_cmd(cmd_valid_i, cmd_i, CMD_BERASE)) begin
          if (!prot_i[cmd_blk_i]) sel_d = sel_q | blk_bit;
        end else if (is_cmd(cmd_valid_i, cmd_i, CMD_RESET)) begin
          sel_d  = '0;
          mode_d = M_READ;
        end
      end
      M_BUSY: begin
        if (ev_done_i) begin
          erase_we_o   = 1'b1;
          erase_mask_o = sel_q & ~ev_fail_i & ~prot_i;
          failed_d     = bad_blk;
          sel_d        = '0;
          mode_d       = (|bad_blk) ? M_ERROR : M_READ;
        end else if (is_cmd(cmd_valid_i, cmd_i, CMD_SUSP)) begin
          mode_d = M_SUSP;
        end
      end
      M_SUSP: if (is_cmd(cmd_valid_i, cmd_i, CMD_RESUME)) mode_d = M_BUSY;
      M_ERROR: begin
        if (is_cmd(cmd_valid_i, cmd_i, CMD_RESET)) begin
          failed_d = '0;
          mode_d   = M_READ;
        end
      end
      default: mode_d = M_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= M_READ;
      sel_q    <= '0;
      failed_q <= '0;
    end else begin
      mode_q   <= mode_d;
      sel_q    <= sel_d;
      failed_q <= failed_d;
    end
  end

  assign mode_o   = mode_q;
  assign sel_o    = sel_q;
  assign failed_o = failed_q;

  AST_ERR_ONLY_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni) (mode_q == M_ERROR && !(cmd_valid_i && cmd_i == CMD_RESET)) |=> (mode_q == M_ERROR)); // R4
  AST_ERR_KEEPS_FAILED: assert property (@(posedge clk_i) disable iff (!rst_ni) (mode_q == M_ERROR && !(cmd_valid_i && cmd_i == CMD_RESET)) |=> $stable(failed_q)); // R9
endmodule

// File: rtl/fes_rdpath.sv
module fes_rdpath
  import fes_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NBLK   = 8,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic [NBLK-1:0]   sel_i,
  input  logic [NBLK-1:0]   failed_i,
  input  logic              rd_en_i,
  input  logic [BLK_W-1:0]  rd_blk_i,
  input  logic [DATA_W-1:0] arr_q_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              tog_o
);
  logic tog_q, erasing, in_sel, in_fail, advance, show_array;
  logic [DATA_W-1:0] status;

  assign erasing    = (mode_i == M_SETUP) || (mode_i == M_BUSY) || (mode_i == M_SUSP);
  assign in_sel     = sel_i[rd_blk_i];
  assign in_fail    = failed_i[rd_blk_i];
  assign advance    = rd_en_i && ((erasing && in_sel) || (mode_i == M_ERROR && in_fail));
  assign show_array = (mode_i == M_READ) || (mode_i == M_SUSP && !in_sel);

  always_comb begin
    status          = '0;
    status[ERR_BIT] = (mode_i == M_ERROR);
    status[TMR_BIT] = (mode_i == M_BUSY) || (mode_i == M_SUSP) || (mode_i == M_ERROR && |failed_i);
    status[TOG_BIT] = tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tog_q <= 1'b0;
    else if (advance) tog_q <= ~tog_q;
  end

  assign rd_data_o = show_array ? arr_q_i : status;
  assign tog_o     = tog_q;
endmodule

// File: rtl/flash_erase_status.sv
module flash_erase_status
  import fes_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NBLK   = 8,
  parameter int WPB    = 4,
  localparam int BLK_W  = $clog2(NBLK),
  localparam int OFF_W  = $clog2(WPB),
  localparam int ADDR_W = BLK_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic [NBLK-1:0]   prot_i,
  input  logic              ev_start_i,
  input  logic              ev_done_i,
  input  logic [NBLK-1:0]   ev_fail_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  mode_e             mode;
  logic [NBLK-1:0]   sel, failed, erase_mask;
  logic              prog_we, erase_we, prog_fault, tog;
  logic [DATA_W-1:0] arr_q;
  logic [DATA_W-1:0] fixed_zero_mask;

  fes_array #(.DATA_W(DATA_W), .NBLK(NBLK), .WPB(WPB)) u_array (
    .clk_i, .rst_ni,
    .prog_we_i(prog_we), .cmd_addr_i, .cmd_data_i,
    .erase_we_i(erase_we), .erase_mask_i(erase_mask),
    .rd_addr_i, .rd_q_o(arr_q), .prog_fault_o(prog_fault)
  );

  fes_ctrl #(.NBLK(NBLK)) u_ctrl (
    .clk_i, .rst_ni, .cmd_valid_i,
    .cmd_i(cmd_e'(cmd_i)),
    .cmd_blk_i(cmd_addr_i[ADDR_W-1:OFF_W]),
    .prot_i, .prog_fault_i(prog_fault),
    .ev_start_i, .ev_done_i, .ev_fail_i,
    .mode_o(mode), .sel_o(sel), .failed_o(failed),
    .prog_we_o(prog_we), .erase_we_o(erase_we), .erase_mask_o(erase_mask)
  );

  fes_rdpath #(.DATA_W(DATA_W), .NBLK(NBLK)) u_rdpath (
    .clk_i, .rst_ni, .mode_i(mode), .sel_i(sel), .failed_i(failed),
    .rd_en_i, .rd_blk_i(rd_addr_i[ADDR_W-1:OFF_W]),
    .arr_q_i(arr_q), .rd_data_o, .tog_o(tog)
  );

  always_comb begin
    fixed_zero_mask          = '1;
    fixed_zero_mask[ERR_BIT] = 1'b0;
    fixed_zero_mask[TMR_BIT] = 1'b0;
    fixed_zero_mask[TOG_BIT] = 1'b0;
  end

  AST_STATUS_SPARE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) (mode != M_READ && mode != M_SUSP) |-> ((rd_data_o & fixed_zero_mask) == '0)); // R12
  AST_SETUP_TIMER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) (mode == M_SETUP) |-> !rd_data_o[TMR_BIT]); // R5
  AST_READ_TOG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (mode == M_READ) |=> $stable(tog)); // R6
  AST_ERR_FLAG_SHOWN: assert property (@(posedge clk_i) disable iff (!rst_ni) (mode == M_ERROR) |-> rd_data_o[ERR_BIT]); // R4
endmodule

// File: tb/flash_erase_status_bench.sv
module flash_erase_status_bench;
  localparam int PERIOD = 10;
  localparam int NBLK = 8, WPB = 4, DEPTH = NBLK * WPB, AW = 5;
  localparam int MR = 0, MP = 1, MS = 2, MB = 3, MU = 4, ME = 5;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, ev_start = 0, ev_done = 0, rd_en = 0;
  logic [2:0] cmd = 0;
  logic [AW-1:0] cmd_addr = 0, rd_addr = 0;
  logic [7:0] cmd_data = 0, rd_data;
  logic [NBLK-1:0] prot = 0, ev_fail = 0;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model
  int m_mode = MR;
  logic [NBLK-1:0] m_sel = 0, m_failed = 0;
  logic m_tog = 0;
  logic [7:0] m_mem [DEPTH];

  logic [7:0] exp_q [$];
  string tag_q [$];

  always #(PERIOD/2) clk = ~clk;

  flash_erase_status u_flash_erase_status (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .prot_i(prot),
    .ev_start_i(ev_start), .ev_done_i(ev_done), .ev_fail_i(ev_fail),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  // monitor
  always @(negedge clk) begin
    if (rd_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rd_data !== e) begin
        bad++;
        $display("FAIL %s addr=%0d actual=%02h expected=%02h", t, rd_addr, rd_data, e);
      end
    end
  end

  task automatic clear_inputs();
    cmd_valid = 0; ev_start = 0; ev_done = 0; rd_en = 0; ev_fail = 0;
  endtask

  task automatic send(input int c, input int a, input logic [7:0] d);
    int b;
    @(posedge clk); #1;
    cmd_valid = 1; cmd = 3'(c); cmd_addr = AW'(a); cmd_data = d;
    b = a / WPB;
    case (m_mode)
      MR: begin
        if (c == 1) begin
          m_mode = ((d & ~m_mem[a]) != 0) ? ME : MP;
          m_mem[a] = m_mem[a] & d;
        end else if (c == 2) begin
          m_sel = prot[b] ? '0 : NBLK'(1) << b; m_mode = MS;
        end else if (c == 3) begin
          m_sel = ~prot; m_mode = MS;
        end
      end
      MS: if (c == 2 && !prot[b]) m_sel[b] = 1'b1;
          else if (c == 6) begin m_sel = 0; m_mode = MR; end
      MB: if (c == 4) m_mode = MU;
      MU: if (c == 5) m_mode = MB;
      ME: if (c == 6) begin m_failed = 0; m_mode = MR; end
      default: ;
    endcase
    @(posedge clk); #1;
    clear_inputs();
  endtask

  task automatic event_pulse(input bit s, input bit dn, input logic [NBLK-1:0] f);
    @(posedge clk); #1;
    ev_start = s; ev_done = dn; ev_fail = f;
    if (m_mode == MS && s) m_mode = MB;
    else if (m_mode == MP && dn) m_mode = MR;
    else if (m_mode == MB && dn) begin
      for (int i = 0; i < DEPTH; i++)
        if (m_sel[i / WPB] && !f[i / WPB]) m_mem[i] = 8'hFF;
      m_failed = m_sel & f;
      m_sel = 0;
      m_mode = (m_failed != 0) ? ME : MR;
    end
    @(posedge clk); #1;
    clear_inputs();
  endtask

  task automatic bus_read(input int a, input string t);
    int b;
    logic [7:0] e;
    @(posedge clk); #1;
    rd_en = 1; rd_addr = AW'(a);
    b = a / WPB;
    if (m_mode == MR || (m_mode == MU && !m_sel[b])) e = m_mem[a];
    else begin
      e = 8'h00;
      e[5] = (m_mode == ME);
      e[3] = (m_mode == MB) || (m_mode == MU) || (m_mode == ME && m_failed != 0);
      e[2] = m_tog;
    end
    exp_q.push_back(e);
    tag_q.push_back(t);
    if (((m_mode == MS || m_mode == MB || m_mode == MU) && m_sel[b]) || (m_mode == ME && m_failed[b]))
      m_tog = ~m_tog;
    @(posedge clk); #1;
    clear_inputs();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    bus_read(0, "R1"); bus_read(13, "R1"); bus_read(31, "R1");

    // R2 program
    send(1, 5, 8'hA5);
    bus_read(5, "R2"); bus_read(20, "R2");
    event_pulse(0, 1, 0);
    bus_read(5, "R2");
    send(1, 5, 8'h0F); event_pulse(0, 1, 0);
    bus_read(5, "R2");

    // R3 program 0->1 fault, R4 commands ignored in error
    send(1, 5, 8'hFF);
    bus_read(5, "R3");
    send(1, 6, 8'h00);
    send(3, 0, 8'h00);
    bus_read(6, "R4");
    send(6, 0, 8'h00);
    bus_read(5, "R3"); bus_read(6, "R4");

    // seed data for erase
    send(1, 1, 8'h12); event_pulse(0, 1, 0);
    send(1, 9, 8'h34); event_pulse(0, 1, 0);
    send(1, 17, 8'h56); event_pulse(0, 1, 0);

    // R5 setup and append, R7 protected block
    prot = 8'b0001_0000;
    send(2, 0, 8'h00);
    bus_read(0, "R5");
    send(2, 17, 8'h00);
    send(2, 9, 8'h00);
    bus_read(9, "R5"); bus_read(17, "R7");
    event_pulse(1, 0, 0);
    // R6 toggle only inside erase set
    bus_read(0, "R6"); bus_read(2, "R6"); bus_read(5, "R6");
    bus_read(10, "R6"); bus_read(17, "R7"); bus_read(28, "R6");

    // R8 suspend / resume
    send(4, 0, 8'h00);
    bus_read(1, "R8"); bus_read(5, "R8"); bus_read(17, "R8"); bus_read(8, "R8");
    send(5, 0, 8'h00);
    bus_read(3, "R8");

    // R10 clean finish
    event_pulse(0, 1, 0);
    bus_read(1, "R10"); bus_read(9, "R10"); bus_read(17, "R7"); bus_read(5, "R10");

    // R11 chip erase, R9 failure location
    send(1, 1, 8'h11); event_pulse(0, 1, 0);
    send(1, 9, 8'h22); event_pulse(0, 1, 0);
    send(1, 25, 8'h33); event_pulse(0, 1, 0);
    send(3, 0, 8'h00);
    event_pulse(1, 0, 0);
    bus_read(25, "R11"); bus_read(17, "R11");
    event_pulse(0, 1, 8'b0010_0100);
    bus_read(9, "R9"); bus_read(10, "R9"); bus_read(1, "R9");
    bus_read(21, "R9"); bus_read(25, "R9");
    send(6, 0, 8'h00);
    bus_read(1, "R11"); bus_read(9, "R9"); bus_read(25, "R11");
    bus_read(17, "R11"); bus_read(5, "R10");

    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule